// File: doc/BRIEF.md
# Dual-Bank Flash Command Decoder

This block is the synchronous command front end of a two-bank NOR-style flash. The host writes 16-bit command words to an address whose bank-select bit chooses bank 0 or bank 1. The block decodes one-cycle commands and two-cycle sequences, and it keeps a separate read mode for each bank: array, status, identifier or query. It sends program, erase, suspend, resume and clear pulses to a small program/erase controller model for each bank. That model reports a busy flag and an 8-bit status byte.

Each bank is handled on its own. A bank that is busy refuses most commands, while the other bank goes on taking commands. A read is captured when the read strobe rises and held for as long as the strobe stays high. A running operation therefore cannot change a status value that has already been captured. A sequence that is broken or malformed sends the addressed bank back to array mode. Reset and the supply-lockout input send both banks there.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset both banks are in array mode, and a read of either bank returns 16'hFFFF. No bank is busy.
- R2: Command 16'h0070 puts only the addressed bank in status mode, and the other bank keeps its mode. A status read returns {8'h00, status}, where status bit 7 is ready (not busy), bit 6 is suspended, bit 5 is erase failed, bit 4 is program failed and bits 3..0 are zero.
- R3: Any of the following sends the addressed bank to array mode with no operation started: an undefined word, any word whose upper byte is not zero, a lone confirm byte (16'h0001, 16'h002F, 16'h0003 or 16'h0000), or a second word other than 16'h00D0 after an erase setup. Any second word other than a protect confirm after 16'h0060 does the same.
- R4: While lockout is high, both banks are held in array mode with no sequence pending, and writes are ignored.
- R5: 16'h00FF is ignored by a bank that is busy, whose mode stays as it was. The same word sent at that time to the other, idle bank puts that bank in array mode.
- R6: A program setup word (16'h0040, 16'h0010, 16'h0030 or 16'h0055) takes the next write to the same bank as its data. The bank's pgm_start bit is then high for exactly the one cycle after that data write. Busy rises on the next edge and stays high for BUSY_CYCLES cycles. The bank reads its status afterwards.
- R7: 16'h0020 or 16'h0080 followed by 16'h00D0 pulses that bank's erase_start bit for one cycle and makes the bank busy. The bank reads its status afterwards.
- R8: rd_data captures the selected content on the first clock with rd_strobe high. It holds that value for as long as rd_strobe stays high, and it is 0 on every clock with rd_strobe low.
- R9: After 16'h0090 to bank 0, bank-0 reads return a value chosen by address: 0 gives MFR_ID, 1 gives DEV_ID, 2 gives the bank-0 protect bit, 3 gives REV_ID, 4 gives PROT_WORD, 5 gives the configuration word, and any other address gives 0. After 16'h0090 to bank 1, every bank-1 read returns the bank-1 protect bit.
- R10: 16'h0060 then 16'h0001 or 16'h002F sets the bank's protect bit, and 16'h0060 then 16'h00D0 clears it. 16'h0060 then 16'h0003 stores wr_addr as the configuration word. Each of these leaves the bank in array mode. A program to a protected bank sets status bit 4 instead of starting, and an erase to a protected bank sets status bit 5 instead of starting.
- R11: 16'h0050 to an idle bank clears its status bits 5 and 4.
- R12: 16'h00B0 to a busy bank suspends it: busy drops and status bit 6 is set. A later 16'h00D0 resumes the operation, which finishes only when its remaining cycles have run.
- R13: After 16'h0098, reads of that bank at addresses 16'h10, 16'h11 and 16'h12 return 16'h0051, 16'h0052 and 16'h0059, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lockout | input | 1 | Low-supply lockout, holds both banks in array mode |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_bank | input | 1 | Bank select of the write |
| wr_addr | input | AW | Write address (used for program data and configuration word) |
| wr_data | input | DW | Command or data word |
| rd_strobe | input | 1 | Combined chip/output enable of a read |
| rd_bank | input | 1 | Bank select of the read |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read result |
| busy | output | 2 | Per-bank busy flag from the controller model |
| pgm_start | output | 2 | Per-bank one-cycle program start |
| erase_start | output | 2 | Per-bank one-cycle erase start |

## Verification
The case hardest to reach is a status read whose strobe is held across the cycle in which the bank's operation finishes. The value held must stay at busy even though the live status has already turned to ready. The stimulus starts a program with a long busy time and waits one cycle so that busy is visible. It then raises the strobe and keeps it high for more cycles than the operation lasts. The cross-bank cases need one bank kept busy while commands go to the other. A suspend needs its command to arrive while the counter is partway through. A behavioural model in the bench follows all of this on every clock.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_SIG, M_CFI} rmode_e;
  typedef enum logic [1:0] {S_IDLE, S_PGM, S_ERS, S_PROT} cstate_e;

  localparam logic [7:0] C_READ    = 8'hFF;
  localparam logic [7:0] C_STAT    = 8'h70;
  localparam logic [7:0] C_SIG     = 8'h90;
  localparam logic [7:0] C_CFI     = 8'h98;
  localparam logic [7:0] C_CLR     = 8'h50;
  localparam logic [7:0] C_PGM     = 8'h40;
  localparam logic [7:0] C_PGM_ALT = 8'h10;
  localparam logic [7:0] C_PGM2    = 8'h30;
  localparam logic [7:0] C_PGM4    = 8'h55;
  localparam logic [7:0] C_BERS    = 8'h20;
  localparam logic [7:0] C_BKERS   = 8'h80;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_CONF    = 8'hD0;
  localparam logic [7:0] C_PSET    = 8'h60;
  localparam logic [7:0] C_PROT    = 8'h01;
  localparam logic [7:0] C_LOCK    = 8'h2F;
  localparam logic [7:0] C_CFG     = 8'h03;
endpackage

// File: rtl/fcd_bank_ctl.sv
module fcd_bank_ctl
  import fcd_pkg::*;
#(
  parameter int DW  = 16,
  parameter bit IDX = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lockout,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  output rmode_e        mode,
  output logic          prot,
  output logic          pgm_go,
  output logic          ers_go,
  output logic          sus_go,
  output logic          res_go,
  output logic          clr_go,
  output logic          cfg_wr
);
  cstate_e    state;
  logic       hit;
  logic [7:0] cb;

  assign hit    = wr_en && (wr_bank == IDX) && !lockout;
  assign cb     = (wr_data[DW-1:8] == '0) ? wr_data[7:0] : 8'h00;
  assign cfg_wr = hit && (state == S_PROT) && (cb == C_CFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      prot <= 1'b0;
    end else if (hit && state == S_PROT) begin
      if (cb == C_PROT || cb == C_LOCK) prot <= 1'b1;
      else if (cb == C_CONF)            prot <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || lockout) begin
      state  <= S_IDLE;
      mode   <= M_ARRAY;
      pgm_go <= 1'b0;
      ers_go <= 1'b0;
      sus_go <= 1'b0;
      res_go <= 1'b0;
      clr_go <= 1'b0;
    end else begin
      pgm_go <= 1'b0;
      ers_go <= 1'b0;
      sus_go <= 1'b0;
      res_go <= 1'b0;
      clr_go <= 1'b0;
      if (hit) begin
        case (state)
          S_IDLE: begin
            if (busy) begin
              case (cb)
                C_STAT:  mode <= M_STATUS;
                C_SIG:   mode <= M_SIG;
                C_CFI:   mode <= M_CFI;
                C_SUSP:  begin mode <= M_STATUS; sus_go <= 1'b1; end
                default: ;
              endcase
            end else begin
              case (cb)
                C_READ:  mode <= M_ARRAY;
                C_STAT:  mode <= M_STATUS;
                C_SIG:   mode <= M_SIG;
                C_CFI:   mode <= M_CFI;
                C_CLR:   clr_go <= 1'b1;
                C_PGM, C_PGM_ALT, C_PGM2, C_PGM4: begin
                  state <= S_PGM;
                  mode  <= M_STATUS;
                end
                C_BERS, C_BKERS: begin
                  state <= S_ERS;
                  mode  <= M_STATUS;
                end
                C_PSET:  state <= S_PROT;
                C_SUSP:  mode <= M_STATUS;
                C_CONF:  begin mode <= M_STATUS; res_go <= 1'b1; end
                default: mode <= M_ARRAY;
              endcase
            end
          end
          S_PGM: begin
            pgm_go <= 1'b1;
            state  <= S_IDLE;
          end
          S_ERS: begin
            state <= S_IDLE;
            if (cb == C_CONF) ers_go <= 1'b1;
            else              mode   <= M_ARRAY;
          end
          default: begin
            state <= S_IDLE;
            mode  <= M_ARRAY;
          end
        endcase
      end
    end
  end

  // R5: a busy bank keeps its mode on read-array
  p_busy_read_array_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && busy && state == S_IDLE && wr_data == DW'(16'h00FF)) |=> (mode == $past(mode)));

  // R4: lockout forces array mode with nothing pending
  p_lockout_array_r4: assert property (@(posedge clk) disable iff (rst)
    lockout |=> (mode == M_ARRAY && state == S_IDLE));

  // R3: broken erase sequence falls back to array
  p_bad_erase_confirm_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && state == S_ERS && wr_data != DW'(16'h00D0)) |=> (mode == M_ARRAY && !ers_go));
endmodule

// File: rtl/fcd_pe_stub.sv
module fcd_pe_stub #(
  parameter int BUSY_CYCLES = 8,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pgm_go,
  input  logic       ers_go,
  input  logic       sus_go,
  input  logic       res_go,
  input  logic       clr_go,
  input  logic       prot,
  output logic       busy,
  output logic [7:0] status
);
  logic          susp, pfail, efail;
  logic [CW-1:0] cnt;

  assign status = {~busy, susp, efail, pfail, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      susp  <= 1'b0;
      pfail <= 1'b0;
      efail <= 1'b0;
      cnt   <= '0;
    end else begin
      if (pgm_go || ers_go) begin
        if (prot) begin
          if (pgm_go) pfail <= 1'b1;
          if (ers_go) efail <= 1'b1;
        end else if (!busy && !susp) begin
          busy <= 1'b1;
          cnt  <= CW'(BUSY_CYCLES - 1);
        end
      end else if (sus_go && busy) begin
        busy <= 1'b0;
        susp <= 1'b1;
      end else if (res_go && susp) begin
        busy <= 1'b1;
        susp <= 1'b0;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
      if (clr_go) begin
        pfail <= 1'b0;
        efail <= 1'b0;
      end
    end
  end

  // R6: busy only rises from a start or a resume
  p_busy_needs_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(pgm_go || ers_go || res_go));

  // R10: a protected bank never becomes busy from a start
  p_protected_stays_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (prot && (pgm_go || ers_go) && !busy && !susp) |=> !busy);
endmodule

// File: rtl/fcd_read_port.sv
module fcd_read_port
  import fcd_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter logic [15:0] MFR_ID    = 16'h0020,
  parameter logic [15:0] DEV_ID    = 16'h00A0,
  parameter logic [15:0] REV_ID    = 16'h0001,
  parameter logic [15:0] PROT_WORD = 16'h1234
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_strobe,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  input  rmode_e        mode0,
  input  rmode_e        mode1,
  input  logic [7:0]    status0,
  input  logic [7:0]    status1,
  input  logic          prot0,
  input  logic          prot1,
  input  logic [DW-1:0] cfg,
  output logic [DW-1:0] rd_data
);
  logic          strobe_q;
  rmode_e        sel_mode;
  logic [7:0]    sel_status;
  logic [DW-1:0] sig_word, cfi_word, value;

  assign sel_mode   = rd_bank ? mode1 : mode0;
  assign sel_status = rd_bank ? status1 : status0;

  always_comb begin
    sig_word = '0;
    if (rd_bank) begin
      sig_word = DW'(prot1);
    end else begin
      case (rd_addr)
        AW'(0):  sig_word = DW'(MFR_ID);
        AW'(1):  sig_word = DW'(DEV_ID);
        AW'(2):  sig_word = DW'(prot0);
        AW'(3):  sig_word = DW'(REV_ID);
        AW'(4):  sig_word = DW'(PROT_WORD);
        AW'(5):  sig_word = cfg;
        default: sig_word = '0;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      AW'(16'h10): cfi_word = DW'(16'h0051);
      AW'(16'h11): cfi_word = DW'(16'h0052);
      AW'(16'h12): cfi_word = DW'(16'h0059);
      default:     cfi_word = '0;
    endcase
  end

  always_comb begin
    case (sel_mode)
      M_STATUS: value = DW'(sel_status);
      M_SIG:    value = sig_word;
      M_CFI:    value = cfi_word;
      default:  value = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      rd_data  <= '0;
    end else begin
      strobe_q <= rd_strobe;
      if (rd_strobe && !strobe_q) rd_data <= value;
      else if (!rd_strobe)        rd_data <= '0;
    end
  end

  // R8: captured word held while the strobe stays active
  p_hold_while_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && strobe_q) |=> $stable(rd_data));

  // R8: released strobe gives zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> (rd_data == '0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int          AW          = 16,
  parameter int          DW          = 16,
  parameter int          BUSY_CYCLES = 8,
  parameter logic [15:0] MFR_ID      = 16'h0020,
  parameter logic [15:0] DEV_ID      = 16'h00A0,
  parameter logic [15:0] REV_ID      = 16'h0001,
  parameter logic [15:0] PROT_WORD   = 16'h1234
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lockout,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_strobe,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    busy,
  output logic [1:0]    pgm_start,
  output logic [1:0]    erase_start
);
  localparam int NB = 2;

  rmode_e        mode_w   [NB];
  logic [7:0]    status_w [NB];
  logic [NB-1:0] prot_w, sus_w, res_w, clr_w, cfgwr_w;
  logic [DW-1:0] cfg;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    fcd_bank_ctl #(.DW(DW), .IDX(b[0])) u_ctl (
      .clk(clk), .rst(rst), .lockout(lockout),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
      .busy(busy[b]), .mode(mode_w[b]), .prot(prot_w[b]),
      .pgm_go(pgm_start[b]), .ers_go(erase_start[b]),
      .sus_go(sus_w[b]), .res_go(res_w[b]), .clr_go(clr_w[b]),
      .cfg_wr(cfgwr_w[b])
    );
    fcd_pe_stub #(.BUSY_CYCLES(BUSY_CYCLES)) u_pe (
      .clk(clk), .rst(rst),
      .pgm_go(pgm_start[b]), .ers_go(erase_start[b]),
      .sus_go(sus_w[b]), .res_go(res_w[b]), .clr_go(clr_w[b]),
      .prot(prot_w[b]), .busy(busy[b]), .status(status_w[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)               cfg <= '0;
    else if (|cfgwr_w)     cfg <= DW'(wr_addr);
  end

  fcd_read_port #(
    .AW(AW), .DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
    .REV_ID(REV_ID), .PROT_WORD(PROT_WORD)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .mode0(mode_w[0]), .mode1(mode_w[1]),
    .status0(status_w[0]), .status1(status_w[1]),
    .prot0(prot_w[0]), .prot1(prot_w[1]), .cfg(cfg), .rd_data(rd_data)
  );

  // R6: a bank never gets program and erase starts together
  p_single_start_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pgm_start[0], erase_start[0]}) && $onehot0({pgm_start[1], erase_start[1]}));
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int BC = 40;

  logic        clk = 1'b0, rst = 1'b1, lockout = 1'b0;
  logic        wr_en = 1'b0, wr_bank = 1'b0, rd_strobe = 1'b0, rd_bank = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  busy, pgm_start, erase_start;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  flash_cmd_decoder #(.BUSY_CYCLES(BC)) u0 (
    .clk(clk), .rst(rst), .lockout(lockout), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .pgm_start(pgm_start), .erase_start(erase_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int          m_mode [2];   // 0 array 1 status 2 sig 3 cfi
  int          m_st   [2];   // 0 idle 1 pgm data 2 erase confirm 3 protect confirm
  int          m_cnt  [2];
  bit          m_busy [2], m_susp [2], m_pf [2], m_ef [2], m_prot [2];
  bit          m_pgm [2], m_ers [2], m_sr [2], m_rr [2], m_clr [2];
  logic [15:0] m_cfg, m_rd;
  bit          m_sq;

  function automatic logic [7:0] m_status(int b);
    return {~m_busy[b], m_susp[b], m_ef[b], m_pf[b], 4'b0000};
  endfunction

  function automatic logic [15:0] m_value(int b, logic [15:0] a);
    case (m_mode[b])
      1: return {8'h00, m_status(b)};
      2: begin
        if (b == 1) return {15'b0, m_prot[1]};
        case (a)
          16'd0: return 16'h0020;
          16'd1: return 16'h00A0;
          16'd2: return {15'b0, m_prot[0]};
          16'd3: return 16'h0001;
          16'd4: return 16'h1234;
          16'd5: return m_cfg;
          default: return 16'h0000;
        endcase
      end
      3: begin
        if (a == 16'h10) return 16'h0051;
        if (a == 16'h11) return 16'h0052;
        if (a == 16'h12) return 16'h0059;
        return 16'h0000;
      end
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic model_step();
    bit ob [2];
    logic [7:0] cb;
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        m_mode[b] = 0; m_st[b] = 0; m_cnt[b] = 0; m_busy[b] = 0; m_susp[b] = 0;
        m_pf[b] = 0; m_ef[b] = 0; m_prot[b] = 0;
        m_pgm[b] = 0; m_ers[b] = 0; m_sr[b] = 0; m_rr[b] = 0; m_clr[b] = 0;
      end
      m_cfg = 0; m_rd = 0; m_sq = 0;
      return;
    end
    if (rd_strobe && !m_sq) m_rd = m_value(int'(rd_bank), rd_addr);
    else if (!rd_strobe)    m_rd = 0;
    m_sq = rd_strobe;
    for (int b = 0; b < 2; b++) begin
      ob[b] = m_busy[b];
      if (m_pgm[b] || m_ers[b]) begin
        if (m_prot[b]) begin
          if (m_pgm[b]) m_pf[b] = 1;
          if (m_ers[b]) m_ef[b] = 1;
        end else if (!m_busy[b] && !m_susp[b]) begin
          m_busy[b] = 1; m_cnt[b] = BC - 1;
        end
      end else if (m_sr[b] && m_busy[b]) begin
        m_busy[b] = 0; m_susp[b] = 1;
      end else if (m_rr[b] && m_susp[b]) begin
        m_busy[b] = 1; m_susp[b] = 0;
      end else if (m_busy[b]) begin
        if (m_cnt[b] == 0) m_busy[b] = 0; else m_cnt[b]--;
      end
      if (m_clr[b]) begin m_pf[b] = 0; m_ef[b] = 0; end
    end
    cb = (wr_data[15:8] == 0) ? wr_data[7:0] : 8'h00;
    for (int b = 0; b < 2; b++) begin
      bit hit;
      hit = wr_en && (int'(wr_bank) == b) && !lockout;
      m_pgm[b] = 0; m_ers[b] = 0; m_sr[b] = 0; m_rr[b] = 0; m_clr[b] = 0;
      if (hit && m_st[b] == 3) begin
        if (cb == 8'h03) m_cfg = wr_addr;
        if (cb == 8'h01 || cb == 8'h2F) m_prot[b] = 1;
        else if (cb == 8'hD0) m_prot[b] = 0;
      end
      if (lockout) begin
        m_st[b] = 0; m_mode[b] = 0;
      end else if (hit) begin
        case (m_st[b])
          0: begin
            if (ob[b]) begin
              if (cb == 8'h70) m_mode[b] = 1;
              else if (cb == 8'h90) m_mode[b] = 2;
              else if (cb == 8'h98) m_mode[b] = 3;
              else if (cb == 8'hB0) begin m_mode[b] = 1; m_sr[b] = 1; end
            end else begin
              case (cb)
                8'hFF: m_mode[b] = 0;
                8'h70: m_mode[b] = 1;
                8'h90: m_mode[b] = 2;
                8'h98: m_mode[b] = 3;
                8'h50: m_clr[b] = 1;
                8'h40, 8'h10, 8'h30, 8'h55: begin m_st[b] = 1; m_mode[b] = 1; end
                8'h20, 8'h80: begin m_st[b] = 2; m_mode[b] = 1; end
                8'h60: m_st[b] = 3;
                8'hB0: m_mode[b] = 1;
                8'hD0: begin m_mode[b] = 1; m_rr[b] = 1; end
                default: m_mode[b] = 0;
              endcase
            end
          end
          1: begin m_pgm[b] = 1; m_st[b] = 0; end
          2: begin
            m_st[b] = 0;
            if (cb == 8'hD0) m_ers[b] = 1; else m_mode[b] = 0;
          end
          default: begin m_st[b] = 0; m_mode[b] = 0; end
        endcase
      end
    end
  endtask

  always @(posedge clk) model_step();

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!finished) begin
      n_chk += 3;
      if (busy !== {m_busy[1], m_busy[0]}) begin
        n_fail++; $display("FAIL R6 model busy: actual %b expected %b", busy, {m_busy[1], m_busy[0]});
      end
      if (rd_data !== m_rd) begin
        n_fail++; $display("FAIL R8 model rd_data: actual %h expected %h", rd_data, m_rd);
      end
      if ({pgm_start, erase_start} !== {m_pgm[1], m_pgm[0], m_ers[1], m_ers[0]}) begin
        n_fail++; $display("FAIL R7 model starts: actual %b expected %b",
          {pgm_start, erase_start}, {m_pgm[1], m_pgm[0], m_ers[1], m_ers[0]});
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit b, logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_bank = b; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(bit b, logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_strobe = 1; rd_bank = b; rd_addr = a;
    @(negedge clk);
    v = rd_data;
    rd_strobe = 0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rst = 0;
    idle(2);
    // R1 reset state
    rd(0, 0, v); chk("R1 bank0 array after reset", v, 16'hFFFF);
    rd(1, 7, v); chk("R1 bank1 array after reset", v, 16'hFFFF);
    chk("R1 no busy after reset", {14'b0, busy}, 16'h0000);

    // R2 status mode is per bank
    wr(0, 0, 16'h0070);
    rd(0, 0, v); chk("R2 bank0 status ready", v, 16'h0080);
    rd(1, 0, v); chk("R2 bank1 unaffected", v, 16'hFFFF);

    // R6 program, R5 busy bank ignores read array
    wr(0, 16'h0100, 16'h0040);
    wr(0, 16'h0100, 16'h1234);
    chk("R6 program start pulse", {14'b0, pgm_start}, 16'h0001);
    @(negedge clk);
    chk("R6 busy after start", {14'b0, busy}, 16'h0001);
    wr(0, 0, 16'h00FF);
    rd(0, 0, v); chk("R5 busy bank keeps status", v, 16'h0000);
    wr(1, 0, 16'h00FF);
    rd(1, 0, v); chk("R5 idle bank takes read array", v, 16'hFFFF);
    idle(BC);
    chk("R6 busy done", {14'b0, busy}, 16'h0000);

    // R8 latch across completion
    wr(0, 16'h0100, 16'h0010);
    wr(0, 16'h0100, 16'hBEEF);
    @(negedge clk);
    rd_strobe = 1; rd_bank = 0; rd_addr = 0;
    for (int i = 0; i < BC + 5; i++) begin
      @(negedge clk);
      chk("R8 held busy status", rd_data, 16'h0000);
    end
    rd_strobe = 0;
    @(negedge clk);
    chk("R8 zero after release", rd_data, 16'h0000);
    rd(0, 0, v); chk("R8 recaptured ready", v, 16'h0080);

    // R7 erase on bank1 while bank0 works
    wr(1, 0, 16'h0020);
    wr(1, 0, 16'h00D0);
    chk("R7 erase start pulse", {14'b0, erase_start}, 16'h0002);
    @(negedge clk);
    chk("R7 bank1 busy", {14'b0, busy}, 16'h0002);
    rd(1, 0, v); chk("R7 bank1 status busy", v, 16'h0000);
    wr(0, 0, 16'h00FF);
    rd(0, 0, v); chk("R5 bank0 array while bank1 busy", v, 16'hFFFF);
    idle(BC);
    wr(1, 0, 16'h0080);
    wr(1, 0, 16'h00D0);
    chk("R7 bank erase start pulse", {14'b0, erase_start}, 16'h0002);
    idle(BC + 2);

    // R3 invalid sequences
    wr(0, 0, 16'h0020); wr(0, 0, 16'h0040);
    rd(0, 0, v); chk("R3 erase then setup", v, 16'hFFFF);
    chk("R3 no busy", {14'b0, busy}, 16'h0000);
    wr(0, 0, 16'h0060); wr(0, 0, 16'h0055);
    rd(0, 0, v); chk("R3 protect then setup", v, 16'hFFFF);
    wr(1, 0, 16'h0070); wr(1, 0, 16'h0001);
    rd(1, 0, v); chk("R3 lone confirm", v, 16'hFFFF);
    wr(1, 0, 16'h0070); wr(1, 0, 16'h0170);
    rd(1, 0, v); chk("R3 upper byte set", v, 16'hFFFF);

    // R10 protect, R11 clear, R9 signature
    wr(0, 0, 16'h0060); wr(0, 0, 16'h0001);
    rd(0, 0, v); chk("R10 array after protect", v, 16'hFFFF);
    wr(0, 0, 16'h0090);
    rd(0, 2, v); chk("R10 protect bit set", v, 16'h0001);
    wr(0, 0, 16'h0040); wr(0, 0, 16'h5555);
    idle(2);
    rd(0, 0, v); chk("R10 program fail", v, 16'h0090);
    wr(0, 0, 16'h0020); wr(0, 0, 16'h00D0);
    idle(2);
    rd(0, 0, v); chk("R10 erase fail", v, 16'h00B0);
    wr(0, 0, 16'h0050);
    idle(1);
    rd(0, 0, v); chk("R11 fails cleared", v, 16'h0080);
    wr(0, 0, 16'h0060); wr(0, 0, 16'h00D0);
    wr(0, 16'h0ABC, 16'h0060); wr(0, 16'h0ABC, 16'h0003);
    wr(0, 0, 16'h0090);
    rd(0, 2, v); chk("R10 unprotected", v, 16'h0000);
    rd(0, 5, v); chk("R10 config word", v, 16'h0ABC);
    rd(0, 0, v); chk("R9 manufacturer", v, 16'h0020);
    rd(0, 1, v); chk("R9 device", v, 16'h00A0);
    rd(0, 3, v); chk("R9 revision", v, 16'h0001);
    rd(0, 4, v); chk("R9 protection word", v, 16'h1234);
    rd(0, 9, v); chk("R9 other address", v, 16'h0000);
    wr(1, 0, 16'h0060); wr(1, 0, 16'h002F);
    wr(1, 0, 16'h0090);
    rd(1, 0, v); chk("R9 bank1 protect at 0", v, 16'h0001);
    rd(1, 5, v); chk("R9 bank1 protect at 5", v, 16'h0001);

    // R12 suspend and resume
    wr(0, 0, 16'h0040); wr(0, 0, 16'h0101);
    idle(4);
    wr(0, 0, 16'h00B0);
    @(negedge clk);
    chk("R12 busy dropped", {14'b0, busy}, 16'h0000);
    rd(0, 0, v); chk("R12 suspended status", v, 16'h00C0);
    wr(0, 0, 16'h00D0);
    @(negedge clk);
    chk("R12 busy resumed", {14'b0, busy}, 16'h0001);
    idle(BC);
    chk("R12 finished", {14'b0, busy}, 16'h0000);

    // R13 query
    wr(1, 0, 16'h0098);
    rd(1, 16'h10, v); chk("R13 query 10", v, 16'h0051);
    rd(1, 16'h11, v); chk("R13 query 11", v, 16'h0052);
    rd(1, 16'h12, v); chk("R13 query 12", v, 16'h0059);
    rd(1, 16'h13, v); chk("R13 query other", v, 16'h0000);

    // R4 lockout
    wr(0, 0, 16'h0070);
    @(negedge clk); lockout = 1;
    @(negedge clk);
    wr(0, 0, 16'h0070);
    @(negedge clk); lockout = 0;
    rd(0, 0, v); chk("R4 bank0 array after lockout", v, 16'hFFFF);
    rd(1, 16'h10, v); chk("R4 bank1 array after lockout", v, 16'hFFFF);

    idle(3);
    summary();
  end
endmodule